// File: doc/BRIEF.md
# I2C Bit-Rate Clock Generator

This block derives the serial clock timing of an I2C master from a fast system clock. Division happens in two stages. A first stage divides by a power of two picked by a 2-bit mode field. A second stage counts those prescaled ticks up to a half-period length. That length is the 8-bit divider value plus a fixed offset of 3, plus 2 more when the filter bit is set. The full SCL period is therefore the prescale factor times twice that half-period count.

Software writes a 4-bit control word that holds the run bit, mode and filter, and writes an 8-bit divider word separately. The block gives a one-cycle bit-phase tick at every half-period boundary, and a one-cycle SCL-rate enable once per full period. It also gives a 50% duty SCL level that a master bit engine can follow. Rate changes made while running are held back until the current half period ends, so no truncated SCL phase is ever produced.

Top module: `sclk_rate_gen`

## Requirements
- R1: After synchronous reset the run bit is clear, `phase_tick` and `scl_en` are 0 and `scl_level` is 1.
- R2: In the control word, bit 0 is the run bit, bits 2:1 are the mode and bit 3 is the filter. The divider is written through its own 8-bit port, and a control write with bit 0 clear produces no ticks.
- R3: Mode values 0, 1, 2 and 3 select a prescale factor P of 32, 16, 8 and 4 system clocks.
- R4: With H = divider + 3 + 2*filter, `phase_tick` is a one-cycle pulse every P*H clocks. The first pulse falls in the (P*H)-th cycle after the clock edge that sets the run bit. This holds at the extremes of the divider (0 and 255).
- R5: `scl_level` starts high and toggles on every `phase_tick`, so it stays high for P*H clocks and low for P*H clocks.
- R6: `scl_en` pulses only on a `phase_tick` where `scl_level` is low and about to rise. It therefore pulses once per full period of 2*P*H clocks.
- R7: While the run bit is clear, no ticks appear and `scl_level` is 1. Setting the run bit again restarts both counters from zero.
- R8: A divider, mode or filter write made while running leaves the current half period at its old length. The new setting applies from the next half-period boundary.
- R9: A setting written in the same cycle as a half-period boundary governs the half period that begins at that boundary.
- R10: Setting the filter bit adds 2 to H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_ctrl | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 4 | Control word: bit 0 run, bits 2:1 mode, bit 3 filter |
| wr_div | input | 1 | Write strobe for the divider word |
| div_wdata | input | 8 | Divider value 0 to 255 |
| phase_tick | output | 1 | One-cycle pulse at each half-period boundary |
| scl_en | output | 1 | One-cycle pulse once per full SCL period |
| scl_level | output | 1 | 50% duty SCL level, high when idle |

## Verification
The two functions that can fall in the same cycle are a half-period terminal count and a configuration write. The bench provokes this by asserting a divider write in the very cycle where `phase_tick` is seen high. The resulting half period must then already have the new length. A second test places the write a cycle after a boundary, and the half period in progress must keep its old length. The bench judges both cases by counting clocks between consecutive ticks against P*H, computed from the written fields.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    localparam int MODE_W        = 2;
    localparam int DIV_W         = 8;
    localparam int CTRL_W        = 4;
    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_MODE_LSB = 1;
    localparam int CTRL_FILT_BIT = 3;

    // rate setting carried between the register stage and the counters
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              filt;
        logic [DIV_W-1:0]  div;
    } rate_cfg_t;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    // prescale factor: 2^(log_max - mode)
    function automatic int unsigned prescale_of(input logic [MODE_W-1:0] m,
                                                input int unsigned log_max);
        return 32'd1 << (log_max - int'(m));
    endfunction

    // half-period length in prescaled ticks
    function automatic int unsigned half_of(input rate_cfg_t c,
                                            input int unsigned offset,
                                            input int unsigned step);
        return int'(c.div) + offset + step * int'(c.filt);
    endfunction

endpackage

// File: rtl/sclk_cfg_regs.sv
module sclk_cfg_regs
    import sclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              wr_div,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              swap,
    output logic              run,
    output rate_cfg_t         active
);

    logic      run_q;
    rate_cfg_t staged_q;
    rate_cfg_t staged_nx;
    rate_cfg_t active_q;

    // staged copy including any write of this cycle (forwarded at a swap)
    always_comb begin
        staged_nx = staged_q;
        if (wr_ctrl) begin
            staged_nx.mode = ctrl_wdata[CTRL_MODE_LSB +: MODE_W];
            staged_nx.filt = ctrl_wdata[CTRL_FILT_BIT];
        end
        if (wr_div) begin
            staged_nx.div = div_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            staged_q <= '0;
            active_q <= '0;
        end else begin
            staged_q <= staged_nx;
            if (wr_ctrl) begin
                run_q <= ctrl_wdata[CTRL_RUN_BIT];
            end
            // idle: follow staged directly; running: only at a boundary
            if (!run_q || swap) begin
                active_q <= staged_nx;
            end
        end
    end

    assign run    = run_q;
    assign active = active_q;

endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
    import sclk_pkg::*;
#(
    parameter int PRE_LOG_MAX = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [MODE_W-1:0] mode,
    output logic              pre_tick
);

    localparam int PRE_W = PRE_LOG_MAX;

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] last;

    assign last     = PRE_W'(prescale_of(mode, PRE_LOG_MAX) - 1);
    assign pre_tick = run && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (pre_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sclk_half_counter.sv
module sclk_half_counter
    import sclk_pkg::*;
#(
    parameter int HALF_W    = 9,
    parameter int OFFSET    = 3,
    parameter int FILT_STEP = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      pre_tick,
    input  rate_cfg_t cfg,
    output logic      phase_tick,
    output logic      scl_en,
    output logic      scl_level
);

    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] last;
    lvl_e              lvl_q;
    logic              tc;

    assign last = HALF_W'(half_of(cfg, OFFSET, FILT_STEP) - 1);
    assign tc   = pre_tick && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            lvl_q <= LVL_HIGH;
        end else if (pre_tick) begin
            if (tc) begin
                cnt_q <= '0;
                lvl_q <= (lvl_q == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign phase_tick = tc;
    assign scl_en     = tc && (lvl_q == LVL_LOW);
    assign scl_level  = run ? lvl_q : 1'b1;

endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
    import sclk_pkg::*;
#(
    parameter int PRE_LOG_MAX = 5,
    parameter int OFFSET      = 3,
    parameter int FILT_STEP   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              wr_div,
    input  logic [DIV_W-1:0]  div_wdata,
    output logic              phase_tick,
    output logic              scl_en,
    output logic              scl_level
);

    localparam int HALF_W = $clog2((1 << DIV_W) + OFFSET + FILT_STEP);

    logic      run;
    logic      pre_tick;
    rate_cfg_t active;

    sclk_cfg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (wr_ctrl),
        .ctrl_wdata (ctrl_wdata),
        .wr_div     (wr_div),
        .div_wdata  (div_wdata),
        .swap       (phase_tick),
        .run        (run),
        .active     (active)
    );

    sclk_prescaler #(
        .PRE_LOG_MAX (PRE_LOG_MAX)
    ) u_pre (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .mode     (active.mode),
        .pre_tick (pre_tick)
    );

    sclk_half_counter #(
        .HALF_W    (HALF_W),
        .OFFSET    (OFFSET),
        .FILT_STEP (FILT_STEP)
    ) u_half (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .pre_tick   (pre_tick),
        .cfg        (active),
        .phase_tick (phase_tick),
        .scl_en     (scl_en),
        .scl_level  (scl_level)
    );

endmodule

// File: rtl/sclk_rate_chk.sv
module sclk_rate_chk (
    input logic clk,
    input logic rst,
    input logic run,
    input logic phase_tick,
    input logic scl_en,
    input logic scl_level
);

    assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!phase_tick && !scl_en && scl_level));

    assert_restart_clean_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> !phase_tick);

    assert_level_toggles_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_tick && run) |=> (scl_level != $past(scl_level)) || !run);

    assert_level_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (!phase_tick && run) |=> $stable(scl_level) || !run);

    assert_rate_en_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
        scl_en |-> (phase_tick && !scl_level));

    assert_tick_single_R4: assert property (@(posedge clk) disable iff (rst)
        phase_tick |=> !phase_tick);

endmodule

bind sclk_rate_gen sclk_rate_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .phase_tick (phase_tick),
    .scl_en     (scl_en),
    .scl_level  (scl_level)
);

// File: tb/sim_sclk_rate_gen.sv
`timescale 1ns/1ps
module sim_sclk_rate_gen;

    localparam int LIM = 40000;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_ctrl;
    logic [3:0] ctrl_wdata;
    logic       wr_div;
    logic [7:0] div_wdata;
    logic       phase_tick;
    logic       scl_en;
    logic       scl_level;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    sclk_rate_gen u0 (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (wr_ctrl),
        .ctrl_wdata (ctrl_wdata),
        .wr_div     (wr_div),
        .div_wdata  (div_wdata),
        .phase_tick (phase_tick),
        .scl_en     (scl_en),
        .scl_level  (scl_level)
    );

    function automatic int half_len(input int m, input int d, input int f);
        return (32 >> m) * (d + 3 + 2 * f);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_ctrl(input int en, input int m, input int f);
        wr_ctrl    = 1'b1;
        ctrl_wdata = {f[0], m[1:0], en[0]};
        @(negedge clk);
        wr_ctrl    = 1'b0;
    endtask

    task automatic do_div(input int d);
        wr_div    = 1'b1;
        div_wdata = d[7:0];
        @(negedge clk);
        wr_div    = 1'b0;
    endtask

    // called in cycle 1 after the enabling edge
    task automatic first_tick(output int n);
        n = 1;
        while (!phase_tick && n < LIM) begin
            @(negedge clk);
            n++;
        end
    endtask

    // called in a tick cycle; returns cycles to next tick and high-level count
    task automatic gap(output int n, output int hi);
        n  = 0;
        hi = 0;
        do begin
            @(negedge clk);
            n++;
            if (scl_level) hi++;
        end while (!phase_tick && n < LIM);
    endtask

    task automatic t_reset();
        chk("R1 phase_tick after reset", int'(phase_tick), 0);
        chk("R1 scl_en after reset", int'(scl_en), 0);
        chk("R1 scl_level after reset", int'(scl_level), 1);
    endtask

    task automatic t_run_bit_clear();
        int seen = 0;
        do_ctrl(0, 3, 1);
        do_div(0);
        for (int i = 0; i < 60; i++) begin
            if (phase_tick || scl_en || !scl_level) seen++;
            @(negedge clk);
        end
        chk("R2 R7 run bit clear gives no ticks", seen, 0);
    endtask

    task automatic t_modes();
        int n;
        for (int m = 0; m < 4; m++) begin
            do_ctrl(0, 0, 0);
            do_div(5);
            do_ctrl(1, m, 0);
            first_tick(n);
            chk($sformatf("R3 mode %0d first half period", m), n, half_len(m, 5, 0));
        end
        do_ctrl(0, 0, 0);
    endtask

    task automatic t_filter();
        int n, hi;
        do_div(0);
        do_ctrl(1, 3, 0);
        first_tick(n);
        chk("R4 divider 0 minimum half period", n, 12);
        do_ctrl(0, 3, 0);
        do_ctrl(1, 3, 1);
        first_tick(n);
        chk("R10 filter adds two to half count", n, 20);
        gap(n, hi);
        chk("R10 filter steady half period", n, 20);
        do_ctrl(0, 0, 0);
    endtask

    task automatic t_extreme();
        int n, hi;
        do_div(255);
        do_ctrl(1, 0, 1);
        first_tick(n);
        chk("R4 divider 255 mode 0 filter 1", n, 8320);
        gap(n, hi);
        chk("R5 max setting low half length", n - hi, 8320);
        chk("R6 scl_en at max setting", int'(scl_en), 1);
        do_ctrl(0, 0, 0);
    endtask

    task automatic t_duty();
        int n, hi, en_gap;
        do_div(1);
        do_ctrl(1, 2, 0);
        first_tick(n);
        chk("R4 first tick after enable", n, 32);
        chk("R6 no scl_en on falling tick", int'(scl_en), 0);
        chk("R5 level high before first tick", int'(scl_level), 1);
        gap(n, hi);
        chk("R4 second half period", n, 32);
        chk("R5 level low for whole half", hi, 0);
        chk("R6 scl_en on rising tick", int'(scl_en), 1);
        gap(n, hi);
        chk("R5 level high for whole half", hi, 32);
        chk("R6 no scl_en on falling tick", int'(scl_en), 0);
        en_gap = n;
        gap(n, hi);
        en_gap += n;
        chk("R6 scl_en spacing is full period", en_gap, 64);
        chk("R6 scl_en present again", int'(scl_en), 1);
        do_ctrl(0, 0, 0);
    endtask

    task automatic t_disable();
        int n, seen;
        do_div(0);
        do_ctrl(1, 3, 0);
        first_tick(n);
        @(negedge clk);
        @(negedge clk);
        do_ctrl(0, 3, 0);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            if (phase_tick || scl_en || !scl_level) seen++;
            @(negedge clk);
        end
        chk("R7 idle outputs while stopped", seen, 0);
        do_ctrl(1, 3, 0);
        first_tick(n);
        chk("R7 restart from zero", n, 12);
        do_ctrl(0, 0, 0);
    endtask

    task automatic t_defer();
        int n, hi;
        do_div(0);
        do_ctrl(1, 3, 0);
        first_tick(n);
        n = 0;
        @(negedge clk);
        n++;
        wr_div    = 1'b1;
        div_wdata = 8'd10;
        @(negedge clk);
        n++;
        wr_div    = 1'b0;
        while (!phase_tick && n < LIM) begin
            @(negedge clk);
            n++;
        end
        chk("R8 current half keeps old divider", n, 12);
        gap(n, hi);
        chk("R8 new divider after boundary", n, 52);
        @(negedge clk);
        wr_ctrl    = 1'b1;
        ctrl_wdata = {1'b0, 2'd1, 1'b1};
        n = 1;
        @(negedge clk);
        n++;
        wr_ctrl    = 1'b0;
        while (!phase_tick && n < LIM) begin
            @(negedge clk);
            n++;
        end
        chk("R8 current half keeps old mode", n, 52);
        gap(n, hi);
        chk("R8 new mode after boundary", n, 208);
        do_ctrl(0, 0, 0);
    endtask

    task automatic t_same_cycle();
        int n, hi;
        do_div(0);
        do_ctrl(1, 3, 0);
        first_tick(n);
        wr_div    = 1'b1;
        div_wdata = 8'd20;
        @(negedge clk);
        wr_div    = 1'b0;
        n = 1;
        while (!phase_tick && n < LIM) begin
            @(negedge clk);
            n++;
        end
        chk("R9 write at boundary applies at once", n, half_len(3, 20, 0));
        gap(n, hi);
        chk("R9 setting persists", n, 92);
        do_ctrl(0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst        = 1'b1;
        wr_ctrl    = 1'b0;
        ctrl_wdata = '0;
        wr_div     = 1'b0;
        div_wdata  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_run_bit_clear();
        t_modes();
        t_filter();
        t_duty();
        t_disable();
        t_defer();
        t_same_cycle();
        t_extreme();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule